// File: doc/BRIEF.md
# Supervisor Timer Compare Interrupt Unit

This unit holds two 64-bit timer compare registers, one for the supervisor level and one for the virtual-supervisor level. On every clock it compares them, as unsigned numbers, against a free-running 64-bit time value. The supervisor level compares against the time value itself. The virtual level compares against the time value plus an offset, with the sum wrapped to 64 bits. From these comparisons it produces the two timer-pending signals that the interrupt logic of the hart consumes.

Software reaches both compare registers through a CSR write port and a combinational read port. On a 32-bit machine, each register is split across a low CSR number and a high CSR number. On a 64-bit machine, the low number reaches the whole register.

Two enable inputs select where the pending signals come from. With the machine-level enable clear, both pending signals come from software-controlled bits. With only the hypervisor-level enable clear, the virtual pending signal comes from software while the supervisor signal stays on its comparator. All comparison results are registered, so a pending signal settles one clock after the input that caused the change.

Top module: `stimer_cmp_unit`

## Requirements
- R1: Both compare registers are 64 bits wide. With `rv32`=1, the low CSR number reads and writes bits 31:0 and the high CSR number reads and writes bits 63:32. Each such access uses `csr_wdata[31:0]`, and reads return the selected half zero-extended to 64 bits. A write to one half leaves the other half unchanged.
- R2: The supervisor compare register decodes at 0x14D (low or full) and 0x15D (high). The virtual compare register decodes at 0x24D (low or full) and 0x25D (high). Any other read address returns zero.
- R3: With `m_en`=1, `s_pend` equals (time ≥ supervisor compare), compared unsigned. It is registered, so it reflects the inputs and register contents one clock edge after they change, and it stays high until the compare value exceeds time.
- R4: With `m_en`=1 and `h_en`=1, the virtual compare condition is ((time + delta) mod 2^64) ≥ virtual compare, compared unsigned.
- R5: In that case, `vs_pend` is the logical OR of `sw_vs_pend` and the virtual compare condition.
- R6: With `m_en`=0, `s_pend` follows `sw_s_pend` and `vs_pend` follows `sw_vs_pend`, regardless of either comparison.
- R7: With `m_en`=1 and `h_en`=0, `vs_pend` follows only `sw_vs_pend`, while `s_pend` still follows its comparator.
- R8: `h_en_eff` reads as `h_en` when `m_en`=1 and as zero when `m_en`=0.
- R9: With `rv32`=0, a write to a low CSR number updates all 64 bits. A write to a high CSR number is ignored, and a read of a high CSR number returns zero.
- R10: Reset loads both compare registers with all ones and clears both pending outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | CSR write strobe |
| csr_waddr | input | 12 | CSR write address |
| csr_wdata | input | 64 | CSR write data |
| csr_raddr | input | 12 | CSR read address |
| csr_rdata | output | 64 | CSR read data (combinational) |
| time_val | input | 64 | Free-running time value |
| time_delta | input | 64 | Offset added to time for the virtual level |
| sw_s_pend | input | 1 | Software supervisor pending bit, used when `m_en`=0 |
| sw_vs_pend | input | 1 | Software-injected virtual pending bit |
| m_en | input | 1 | Machine-level compare enable |
| h_en | input | 1 | Hypervisor-level compare enable |
| rv32 | input | 1 | 1 = 32-bit CSR access mode |
| h_en_eff | output | 1 | Effective hypervisor-level enable |
| s_pend | output | 1 | Supervisor timer pending |
| vs_pend | output | 1 | Virtual-supervisor timer pending |

## Verification
The bench builds the unit with its default parameters: a 64-bit compare width, 12-bit CSR addresses and the standard CSR numbers. At this width, unsigned ordering near the top bit can be tested directly, with compare values above 2^63. The 64-bit wrap of time plus delta is also reachable, which lets the bench tell a truncated sum from an untruncated one. Because the `rv32` strap is a live input, one build covers both the split-half and full-width access paths. The bench can also switch widths while a register holds data and read the same contents through the other view.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int unsigned CMP_W = 64;
    localparam int unsigned HALF_W = CMP_W / 2;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned NLVL = 2;

    localparam logic [ADDR_W-1:0] S_LO_ADDR = 12'h14D;
    localparam logic [ADDR_W-1:0] S_HI_ADDR = 12'h15D;
    localparam logic [ADDR_W-1:0] V_LO_ADDR = 12'h24D;
    localparam logic [ADDR_W-1:0] V_HI_ADDR = 12'h25D;

    localparam logic [ADDR_W-1:0] LO_ADDRS [NLVL] = '{S_LO_ADDR, V_LO_ADDR};
    localparam logic [ADDR_W-1:0] HI_ADDRS [NLVL] = '{S_HI_ADDR, V_HI_ADDR};

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
    } cmp_state_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;
endpackage

// File: rtl/stc_cmp_reg.sv
module stc_cmp_reg
    import stc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR = 12'h14D,
    parameter logic [ADDR_W-1:0] HI_ADDR = 12'h15D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rv32,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CMP_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [CMP_W-1:0]  rdata,
    output logic [CMP_W-1:0]  val
);
    cmp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && waddr == LO_ADDR) begin
            if (rv32) st_d.cmp[HALF_W-1:0] = wdata[HALF_W-1:0];
            else      st_d.cmp = wdata;
        end else if (we && rv32 && waddr == HI_ADDR) begin
            st_d.cmp[CMP_W-1:HALF_W] = wdata[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cmp: '1};
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (raddr == LO_ADDR) begin
            if (rv32) rdata[HALF_W-1:0] = st_q.cmp[HALF_W-1:0];
            else      rdata = st_q.cmp;
        end else if (raddr == HI_ADDR && rv32) begin
            rdata[HALF_W-1:0] = st_q.cmp[CMP_W-1:HALF_W];
        end
    end

    assign val = st_q.cmp;

    // R9: a high-half write in 64-bit mode leaves the register untouched
    a_r9_hi_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !rv32 && waddr == HI_ADDR) |=> $stable(val));

    // R1: a low-half write in 32-bit mode keeps the upper half
    a_r1_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rv32 && waddr == LO_ADDR) |=> (val[CMP_W-1:HALF_W] == $past(val[CMP_W-1:HALF_W])));
endmodule

// File: rtl/stc_pend.sv
module stc_pend
    import stc_pkg::*;
#(
    parameter bit OR_SW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cur,
    input  logic [CMP_W-1:0] cmp,
    input  logic             cmp_en,
    input  logic             sw_bit,
    output logic             pend
);
    pend_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        hit = (cur >= cmp);
        if (cmp_en) st_d.pend = hit | (OR_SW & sw_bit);
        else        st_d.pend = sw_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: 1'b0};
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    // R6/R7: with compare disabled the output tracks the software bit
    a_r6_sw_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> (pend == $past(sw_bit)));
endmodule

// File: rtl/stimer_cmp_unit.sv
module stimer_cmp_unit
    import stc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_waddr,
    input  logic [CMP_W-1:0]  csr_wdata,
    input  logic [ADDR_W-1:0] csr_raddr,
    output logic [CMP_W-1:0]  csr_rdata,
    input  logic [CMP_W-1:0]  time_val,
    input  logic [CMP_W-1:0]  time_delta,
    input  logic              sw_s_pend,
    input  logic              sw_vs_pend,
    input  logic              m_en,
    input  logic              h_en,
    input  logic              rv32,
    output logic              h_en_eff,
    output logic              s_pend,
    output logic              vs_pend
);
    logic [CMP_W-1:0] cmp_val [NLVL];
    logic [CMP_W-1:0] rd_part [NLVL];
    logic [CMP_W-1:0] cur_time [NLVL];
    logic             lvl_en [NLVL];
    logic             lvl_sw [NLVL];
    logic             lvl_pend [NLVL];

    assign h_en_eff = m_en & h_en;

    assign cur_time[0] = time_val;
    assign cur_time[1] = time_val + time_delta;
    assign lvl_en[0]   = m_en;
    assign lvl_en[1]   = h_en_eff;
    assign lvl_sw[0]   = sw_s_pend;
    assign lvl_sw[1]   = sw_vs_pend;

    for (genvar gi = 0; gi < NLVL; gi++) begin : g_lvl
        stc_cmp_reg #(
            .LO_ADDR(LO_ADDRS[gi]),
            .HI_ADDR(HI_ADDRS[gi])
        ) i_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .rv32 (rv32),
            .we   (csr_we),
            .waddr(csr_waddr),
            .wdata(csr_wdata),
            .raddr(csr_raddr),
            .rdata(rd_part[gi]),
            .val  (cmp_val[gi])
        );

        stc_pend #(
            .OR_SW(gi == 1)
        ) i_pend (
            .clk   (clk),
            .rst_n (rst_n),
            .cur   (cur_time[gi]),
            .cmp   (cmp_val[gi]),
            .cmp_en(lvl_en[gi]),
            .sw_bit(lvl_sw[gi]),
            .pend  (lvl_pend[gi])
        );
    end

    always_comb begin
        csr_rdata = '0;
        for (int i = 0; i < NLVL; i++) csr_rdata |= rd_part[i];
    end

    assign s_pend  = lvl_pend[0];
    assign vs_pend = lvl_pend[1];

    // R3: comparator result shows up one edge later
    a_r3_s_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && time_val >= cmp_val[0]) |=> s_pend);
    a_r3_s_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && time_val < cmp_val[0]) |=> !s_pend);

    // R5: software virtual bit always forces the virtual pending output
    a_r5_sw_or: assert property (@(posedge clk) disable iff (!rst_n)
        sw_vs_pend |=> vs_pend);

    // R7: virtual level disabled while machine level enabled
    a_r7_vs_sw_only: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && !h_en) |=> (vs_pend == $past(sw_vs_pend)));
endmodule

// File: tb/test_stimer_cmp_unit.sv
module test_stimer_cmp_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        csr_we;
    logic [11:0] csr_waddr;
    logic [63:0] csr_wdata;
    logic [11:0] csr_raddr;
    logic [63:0] csr_rdata;
    logic [63:0] time_val;
    logic [63:0] time_delta;
    logic        sw_s_pend, sw_vs_pend, m_en, h_en, rv32;
    logic        h_en_eff, s_pend, vs_pend;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stimer_cmp_unit i_stimer_cmp_unit (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_waddr(csr_waddr),
        .csr_wdata(csr_wdata), .csr_raddr(csr_raddr), .csr_rdata(csr_rdata),
        .time_val(time_val), .time_delta(time_delta), .sw_s_pend(sw_s_pend),
        .sw_vs_pend(sw_vs_pend), .m_en(m_en), .h_en(h_en), .rv32(rv32),
        .h_en_eff(h_en_eff), .s_pend(s_pend), .vs_pend(vs_pend)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        csr_we = 1'b1; csr_waddr = a; csr_wdata = d;
        @(posedge clk);
        @(negedge clk);
        csr_we = 1'b0;
        settle();
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [63:0] exp);
        csr_raddr = a;
        #1;
        chk(req, csr_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R10 s_pend", {63'd0, s_pend}, 64'd0);
        chk("R10 vs_pend", {63'd0, vs_pend}, 64'd0);
        rd_chk("R10 s cmp ones", 12'h14D, '1);
        rd_chk("R10 v cmp ones", 12'h24D, '1);
    endtask

    task automatic t_rv64();
        wr(12'h14D, 64'h0000_0001_0000_0100);
        rd_chk("R9 full write", 12'h14D, 64'h0000_0001_0000_0100);
        wr(12'h15D, 64'hDEAD_BEEF_DEAD_BEEF);
        rd_chk("R9 hi write ignored", 12'h14D, 64'h0000_0001_0000_0100);
        rd_chk("R9 hi reads zero", 12'h15D, 64'd0);
        rd_chk("R2 unknown addr", 12'h14E, 64'd0);
    endtask

    task automatic t_s_cmp();
        m_en = 1'b1;
        wr(12'h14D, 64'h0000_0100_0000_0000);
        time_val = 64'h0000_00FF_FFFF_FFFF;
        settle();
        chk("R3 below", {63'd0, s_pend}, 64'd0);
        time_val = 64'h0000_0100_0000_0000;
        #1;
        chk("R3 not before edge", {63'd0, s_pend}, 64'd0);
        settle();
        chk("R3 equal", {63'd0, s_pend}, 64'd1);
        time_val = 64'h0000_0100_0000_0005;
        settle();
        chk("R3 above", {63'd0, s_pend}, 64'd1);
        wr(12'h14D, 64'h0000_0100_0000_0006);
        chk("R3 cleared by write", {63'd0, s_pend}, 64'd0);
        wr(12'h14D, 64'h8000_0000_0000_0000);
        time_val = 64'h7FFF_FFFF_FFFF_FFFF;
        settle();
        chk("R3 unsigned low", {63'd0, s_pend}, 64'd0);
        time_val = 64'hFFFF_FFFF_0000_0000;
        settle();
        chk("R3 unsigned high", {63'd0, s_pend}, 64'd1);
    endtask

    task automatic t_v_cmp();
        h_en = 1'b1;
        wr(12'h24D, 64'd100);
        time_val = 64'd50; time_delta = 64'd49;
        settle();
        chk("R4 sum below", {63'd0, vs_pend}, 64'd0);
        time_delta = 64'd50;
        settle();
        chk("R4 sum equal", {63'd0, vs_pend}, 64'd1);
        time_val = 64'hFFFF_FFFF_FFFF_FFF6; time_delta = 64'd20;
        settle();
        chk("R4 wrapped sum", {63'd0, vs_pend}, 64'd0);
        sw_vs_pend = 1'b1;
        settle();
        chk("R5 sw forces", {63'd0, vs_pend}, 64'd1);
        sw_vs_pend = 1'b0;
        wr(12'h24D, 64'd5);
        chk("R4 wrapped hit", {63'd0, vs_pend}, 64'd1);
    endtask

    task automatic t_h_off();
        h_en = 1'b0;
        wr(12'h14D, 64'd0);
        chk("R7 vs sw only", {63'd0, vs_pend}, 64'd0);
        chk("R7 s still cmp", {63'd0, s_pend}, 64'd1);
        chk("R8 h_en_eff off", {63'd0, h_en_eff}, 64'd0);
        sw_vs_pend = 1'b1;
        settle();
        chk("R7 vs follows sw", {63'd0, vs_pend}, 64'd1);
        sw_vs_pend = 1'b0;
    endtask

    task automatic t_m_off();
        h_en = 1'b1; m_en = 1'b0;
        settle();
        chk("R8 h_en_eff gated", {63'd0, h_en_eff}, 64'd0);
        chk("R6 s follows sw 0", {63'd0, s_pend}, 64'd0);
        chk("R6 vs follows sw 0", {63'd0, vs_pend}, 64'd0);
        sw_s_pend = 1'b1;
        settle();
        chk("R6 s follows sw 1", {63'd0, s_pend}, 64'd1);
        sw_s_pend = 1'b0;
        m_en = 1'b1;
        settle();
        chk("R8 h_en_eff on", {63'd0, h_en_eff}, 64'd1);
        chk("R4 vs back on cmp", {63'd0, vs_pend}, 64'd1);
    endtask

    task automatic t_rv32();
        rv32 = 1'b1;
        wr(12'h24D, 64'hFFFF_FFFF_1234_5678);
        wr(12'h25D, 64'hAAAA_AAAA_9ABC_DEF0);
        rd_chk("R1 lo half", 12'h24D, 64'h0000_0000_1234_5678);
        rd_chk("R1 hi half", 12'h25D, 64'h0000_0000_9ABC_DEF0);
        wr(12'h15D, 64'h0000_0000_0000_0042);
        rd_chk("R2 s hi half", 12'h15D, 64'h0000_0000_0000_0042);
        rd_chk("R1 s lo kept", 12'h14D, 64'd0);
        rv32 = 1'b0;
        #1;
        rd_chk("R1 full view", 12'h24D, 64'h9ABC_DEF0_1234_5678);
        rd_chk("R1 s full view", 12'h14D, 64'h0000_0042_0000_0000);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; csr_we = 1'b0; csr_waddr = '0; csr_wdata = '0; csr_raddr = '0;
        time_val = '0; time_delta = '0; sw_s_pend = 1'b0; sw_vs_pend = 1'b0;
        m_en = 1'b0; h_en = 1'b0; rv32 = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rv64();
        t_s_cmp();
        t_v_cmp();
        t_h_off();
        t_m_off();
        t_rv32();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule